// File: doc/BRIEF.md
# Page Translation Cache

This block keeps recently used page mappings in a small fully associative store. Each cycle it can translate one virtual address to a physical address. Pages are a fixed 4 KB, so the low 12 address bits pass straight through. The upper 20 bits, the virtual page number, are compared against every stored entry at the same time. On a match the physical page number is put in front of the untranslated offset in the same cycle.

When no entry matches, the block raises a miss flag and fetches nothing itself. An external handler walks the page tables, installs the mapping through the refill port, and then retries the access.

Every entry carries three status bits: valid, referenced and dirty.
- Any lookup that hits sets the referenced bit of that entry.
- A write lookup that hits also sets the dirty bit.
- The hit outputs show the status the entry had before the current access.

A refill goes into the lowest-numbered invalid entry. If every entry is valid, it replaces the least recently used one. A flush input invalidates the whole store in one cycle.

Top module: `xlate_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss with `hit_ref` and `hit_dirty` at 0.
- R2: A lookup with `lk_valid`=1 whose page number (`lk_vaddr[31:12]`) matches a valid entry raises `lk_hit` combinationally in the same cycle. In that case `lk_paddr[31:12]` is the entry's physical page number.
- R3: `lk_paddr[11:0]` always equals `lk_vaddr[11:0]`, whether the lookup hits or misses.
- R4: A lookup with `lk_valid`=1 and no matching valid entry raises `lk_miss`, with `lk_hit`=0 and `lk_paddr[31:12]`=0. With `lk_valid`=0, both `lk_hit` and `lk_miss` are 0 and no state changes.
- R5: A hitting lookup sets the entry's referenced bit from the next cycle on. `hit_ref` reports the value held before the current access.
- R6: A hitting lookup with `lk_write`=1 sets the entry's dirty bit from the next cycle on. A read never clears it, and `hit_dirty` reports the value held before the current access.
- R7: A refill (`fill_valid`=1) writes the lowest-numbered invalid entry. If no entry is invalid, it writes the least recently used entry, judged on the state before this cycle.
- R8: A refilled entry takes its referenced and dirty bits from `fill_ref` and `fill_dirty`, so both are 0 unless the refill supplies them.
- R9: `flush`=1 invalidates every entry at the next edge. It overrides a refill and any status update in the same cycle.
- R10: When a lookup hit and a refill fall in one cycle, the lookup result comes from the state before the edge. The hit entry is marked as used first and the refilled entry second. If both name the same entry, the refill contents win.
- R11: A hit or a refill makes the entry the most recently used. A miss or an idle cycle leaves the recency order unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Install a mapping this cycle |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_ref | input | 1 | Initial referenced bit of the installed entry |
| fill_dirty | input | 1 | Initial dirty bit of the installed entry |
| flush | input | 1 | Invalidate all entries |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_miss | output | 1 | Lookup found no valid entry |
| lk_paddr | output | 32 | Translated physical address |
| hit_ref | output | 1 | Referenced bit of the matched entry before this access |
| hit_dirty | output | 1 | Dirty bit of the matched entry before this access |

## Verification
A lookup and a refill can land in the same cycle. The bench provokes this on purpose by looking up the least recently used page while a new page is installed, so the victim is the entry being hit. It checks that the hit is still reported from the old contents, and that the old page misses on the next cycle. Flush is also paired with a same-cycle refill and write hit, and the following lookups must all miss. A long random phase over a page pool larger than the store mixes all three events. A behavioural model keeps the recency order as a list and is compared against the outputs every cycle.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int unsigned XC_OFF_W = 12;
  localparam int unsigned XC_VPN_W = 20;
  localparam int unsigned XC_PPN_W = 20;
  localparam int unsigned XC_VA_W  = XC_VPN_W + XC_OFF_W;
  localparam int unsigned XC_PA_W  = XC_PPN_W + XC_OFF_W;

  typedef struct packed {
    logic                vld;
    logic                rf;
    logic                dt;
    logic [XC_VPN_W-1:0] vpn;
    logic [XC_PPN_W-1:0] ppn;
  } xc_entry_t;
endpackage

// File: rtl/xc_match.sv
module xc_match
  import xc_pkg::*;
#(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  xc_entry_t [ENTRIES-1:0] ent,
  input  logic [XC_VPN_W-1:0]     vpn,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = ent[g].vld && (ent[g].vpn == vpn);
  end

  assign hit = |eq;

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (eq[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vld_vec,
  input  logic [IDX_W-1:0]   lru_idx,
  output logic [IDX_W-1:0]   victim_idx
);
  logic             any_free;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_vec[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign victim_idx = any_free ? free_idx : lru_idx;
endmodule

// File: rtl/xc_recency.sv
module xc_recency #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_idx,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  output logic [IDX_W-1:0] lru_idx
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] rank_q [ENTRIES];
  logic [IDX_W-1:0] rank_d [ENTRIES];
  logic [IDX_W-1:0] prev_a;
  logic [IDX_W-1:0] prev_b;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) rank_d[i] = rank_q[i];
    prev_a = rank_d[a_idx];
    if (a_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rank_d[i] < prev_a) rank_d[i] = rank_d[i] + 1'b1;
      end
      rank_d[a_idx] = '0;
    end
    prev_b = rank_d[b_idx];
    if (b_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rank_d[i] < prev_b) rank_d[i] = rank_d[i] + 1'b1;
      end
      rank_d[b_idx] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IDX_W'(i);
    end else if (a_en || b_en) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= rank_d[i];
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rank_q[i] == OLDEST) lru_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xc_pkg::*;
#(
  parameter int unsigned ENTRIES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lk_valid,
  input  logic                lk_write,
  input  logic [XC_VA_W-1:0]  lk_vaddr,
  input  logic                fill_valid,
  input  logic [XC_VPN_W-1:0] fill_vpn,
  input  logic [XC_PPN_W-1:0] fill_ppn,
  input  logic                fill_ref,
  input  logic                fill_dirty,
  input  logic                flush,
  output logic                lk_hit,
  output logic                lk_miss,
  output logic [XC_PA_W-1:0]  lk_paddr,
  output logic                hit_ref,
  output logic                hit_dirty
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  xc_entry_t [ENTRIES-1:0] ent_q;
  xc_entry_t [ENTRIES-1:0] ent_d;

  logic [XC_VPN_W-1:0] lk_vpn;
  logic                match_hit;
  logic [IDX_W-1:0]    match_idx;
  logic [IDX_W-1:0]    victim_idx;
  logic [IDX_W-1:0]    lru_idx;
  logic [ENTRIES-1:0]  vld_vec;
  logic                touch_a;
  logic                touch_b;
  logic                state_en;
  logic [XC_PPN_W-1:0] hit_ppn;

  assign lk_vpn = lk_vaddr[XC_VA_W-1:XC_OFF_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign vld_vec[g] = ent_q[g].vld;
  end

  xc_match #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_match (
    .ent (ent_q),
    .vpn (lk_vpn),
    .hit (match_hit),
    .idx (match_idx)
  );

  xc_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .vld_vec    (vld_vec),
    .lru_idx    (lru_idx),
    .victim_idx (victim_idx)
  );

  xc_recency #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_recency (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_en    (touch_a),
    .a_idx   (match_idx),
    .b_en    (touch_b),
    .b_idx   (victim_idx),
    .lru_idx (lru_idx)
  );

  // Lookup side, combinational from registered state.
  assign lk_hit    = lk_valid & match_hit;
  assign lk_miss   = lk_valid & ~match_hit;
  assign hit_ppn   = lk_hit ? ent_q[match_idx].ppn : '0;
  assign lk_paddr  = {hit_ppn, lk_vaddr[XC_OFF_W-1:0]};
  assign hit_ref   = lk_hit & ent_q[match_idx].rf;
  assign hit_dirty = lk_hit & ent_q[match_idx].dt;

  // Flush outranks both same-cycle updates.
  assign touch_a  = lk_hit & ~flush;
  assign touch_b  = fill_valid & ~flush;
  assign state_en = flush | touch_a | touch_b;

  always_comb begin
    ent_d = ent_q;
    if (flush) begin
      for (int i = 0; i < ENTRIES; i++) ent_d[i].vld = 1'b0;
    end
    if (touch_a) begin
      ent_d[match_idx].rf = 1'b1;
      if (lk_write) ent_d[match_idx].dt = 1'b1;
    end
    if (touch_b) begin
      ent_d[victim_idx].vld = 1'b1;
      ent_d[victim_idx].rf  = fill_ref;
      ent_d[victim_idx].dt  = fill_dirty;
      ent_d[victim_idx].vpn = fill_vpn;
      ent_d[victim_idx].ppn = fill_ppn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (state_en) begin
      ent_q <= ent_d;
    end
  end
endmodule

// File: rtl/xc_checker.sv
module xc_checker
  import xc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_write,
  input logic [XC_VA_W-1:0] lk_vaddr,
  input logic               lk_hit,
  input logic               lk_miss,
  input logic [XC_PA_W-1:0] lk_paddr,
  input logic               hit_ref,
  input logic               hit_dirty,
  input logic               flush,
  input logic               fill_valid
);
  // R4
  a_r4_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_miss));

  // R4
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss));

  // R3
  a_r3_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    lk_paddr[XC_OFF_W-1:0] == lk_vaddr[XC_OFF_W-1:0]);

  // R9
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);

  // R5
  a_r5_ref_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && $past(lk_hit && !flush && !fill_valid) &&
     lk_vaddr[XC_VA_W-1:XC_OFF_W] == $past(lk_vaddr[XC_VA_W-1:XC_OFF_W]))
    |-> hit_ref);

  // R6
  a_r6_dirty_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && $past(lk_hit && lk_write && !flush && !fill_valid) &&
     lk_vaddr[XC_VA_W-1:XC_OFF_W] == $past(lk_vaddr[XC_VA_W-1:XC_OFF_W]))
    |-> hit_dirty);
endmodule

bind xlate_cache xc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_valid   (lk_valid),
  .lk_write   (lk_write),
  .lk_vaddr   (lk_vaddr),
  .lk_hit     (lk_hit),
  .lk_miss    (lk_miss),
  .lk_paddr   (lk_paddr),
  .hit_ref    (hit_ref),
  .hit_dirty  (hit_dirty),
  .flush      (flush),
  .fill_valid (fill_valid)
);

// File: tb/xlate_cache_tb.sv
`timescale 1ns/1ps
module xlate_cache_tb;
  localparam int N = 16;

  logic        clk;
  logic        rst_n;
  logic        lk_valid, lk_write;
  logic [31:0] lk_vaddr;
  logic        fill_valid;
  logic [19:0] fill_vpn, fill_ppn;
  logic        fill_ref, fill_dirty, flush;
  logic        lk_hit, lk_miss, hit_ref, hit_dirty;
  logic [31:0] lk_paddr;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Behavioural model
  bit        m_vld [N];
  bit        m_ref [N];
  bit        m_dt  [N];
  bit [19:0] m_vpn [N];
  bit [19:0] m_ppn [N];
  int        m_order [$];

  xlate_cache u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_ref(fill_ref), .fill_dirty(fill_dirty),
    .flush(flush), .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .hit_ref(hit_ref), .hit_dirty(hit_dirty)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int mfind(bit [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic int mvictim();
    for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
    return m_order[$];
  endfunction

  task automatic mtouch(int k);
    for (int i = 0; i < m_order.size(); i++) begin
      if (m_order[i] == k) begin
        m_order.delete(i);
        break;
      end
    end
    m_order.push_front(k);
  endtask

  task automatic step(input bit v, input bit w, input bit [31:0] va,
                      input bit fv, input bit [19:0] fvpn, input bit [19:0] fppn,
                      input bit fr, input bit fd, input bit fl, input string tag);
    int hi, vi;
    bit e_hit, e_miss, e_ref, e_dt;
    bit [31:0] e_pa;
    lk_valid = v; lk_write = w; lk_vaddr = va;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn;
    fill_ref = fr; fill_dirty = fd; flush = fl;
    #1;
    hi = mfind(va[31:12]);
    vi = mvictim();
    e_hit  = v && (hi >= 0);
    e_miss = v && (hi < 0);
    e_pa   = {e_hit ? m_ppn[hi] : 20'h0, va[11:0]};
    e_ref  = e_hit && m_ref[hi];
    e_dt   = e_hit && m_dt[hi];
    compared++;
    if (lk_hit !== e_hit || lk_miss !== e_miss || lk_paddr !== e_pa ||
        hit_ref !== e_ref || hit_dirty !== e_dt) begin
      mismatched++;
      $display("FAIL %s: va=%h got hit=%b miss=%b pa=%h ref=%b dt=%b exp hit=%b miss=%b pa=%h ref=%b dt=%b",
               tag, va, lk_hit, lk_miss, lk_paddr, hit_ref, hit_dirty,
               e_hit, e_miss, e_pa, e_ref, e_dt);
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else begin
      if (e_hit) begin
        m_ref[hi] = 1;
        if (w) m_dt[hi] = 1;
        mtouch(hi);
      end
      if (fv) begin
        m_vld[vi] = 1; m_ref[vi] = fr; m_dt[vi] = fd;
        m_vpn[vi] = fvpn; m_ppn[vi] = fppn;
        mtouch(vi);
      end
    end
    @(negedge clk);
  endtask

  task automatic rd(input bit [31:0] va, input string tag);
    step(1, 0, va, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic fill(input bit [19:0] vpn, input bit [19:0] ppn,
                      input bit fr, input bit fd, input string tag);
    step(0, 0, 0, 1, vpn, ppn, fr, fd, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_ref[i] = 0; m_dt[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
      m_order.push_back(i);
    end
    rst_n = 1'b0;
    lk_valid = 0; lk_write = 0; lk_vaddr = 0; fill_valid = 0;
    fill_vpn = 0; fill_ppn = 0; fill_ref = 0; fill_dirty = 0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 empty after reset, R4 idle
    rd(32'h1234_5678, "R1");
    step(0, 0, 32'h0010_0abc, 0, 0, 0, 0, 0, 0, "R4");

    // R7 fill all sixteen slots in order, R8 one with bits supplied
    for (int i = 0; i < N; i++)
      fill(20'h00100 + 20'(i), 20'h80000 + 20'(i * 3), (i == 5), (i == 5), "R7");
    rd(32'h0010_5000, "R8");
    rd(32'h0010_0000, "R8");

    // R2/R3 hits with several offsets
    rd(32'h0010_3fff, "R2");
    rd(32'h0010_7123, "R3");
    rd(32'h0010_f000, "R2");
    // R4 miss on unknown page
    rd(32'h0099_9001, "R4");

    // R5 ref seen on second read, R6 dirty after write, read keeps it
    rd(32'h0010_9010, "R5");
    rd(32'h0010_9020, "R5");
    step(1, 1, 32'h0010_a004, 0, 0, 0, 0, 0, 0, "R6");
    rd(32'h0010_a008, "R6");
    rd(32'h0010_a00c, "R6");

    // R11 a miss does not refresh; then replace the LRU page
    rd(32'h0077_7000, "R11");
    fill(20'h00200, 20'h12345, 0, 0, "R11");
    for (int i = 0; i < N; i++) rd({20'h00100 + 20'(i), 12'h044}, "R7");
    rd(32'h0020_0044, "R11");

    // R10 lookup hits the LRU entry while a refill evicts it
    begin
      bit [19:0] old_vpn;
      old_vpn = m_vpn[m_order[$]];
      step(1, 1, {old_vpn, 12'h321}, 1, 20'h00300, 20'h0abcd, 0, 0, 0, "R10");
      rd({old_vpn, 12'h321}, "R10");
      rd(32'h0030_0321, "R10");
    end

    // R9 flush with a same-cycle refill and write hit
    step(1, 1, 32'h0030_0000, 1, 20'h00400, 20'h00444, 1, 1, 1, "R9");
    rd(32'h0030_0000, "R9");
    rd(32'h0040_0000, "R9");
    rd(32'h0010_2000, "R9");
    fill(20'h00500, 20'h00555, 0, 0, "R7");
    rd(32'h0050_0abc, "R8");

    // Mixed random traffic over a pool larger than the store
    for (int k = 0; k < 3000; k++) begin
      bit v, w, fv, fl;
      bit [19:0] lv, fvp;
      v   = ($urandom % 4) != 0;
      w   = $urandom % 2;
      lv  = 20'h00600 + 20'($urandom % 24);
      fvp = 20'h00600 + 20'($urandom % 24);
      fv  = ($urandom % 3) == 0;
      if (mfind(fvp) >= 0) fv = 0;
      fl  = ($urandom % 97) == 0;
      step(v, w, {lv, 12'($urandom)}, fv, fvp, 20'($urandom),
           $urandom % 2, $urandom % 2, fl, "R10");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule